// File: doc/BRIEF.md
# Cache Line Span Splitter

This block sits in front of a cache tag controller. It takes one memory access, given as a start address, a byte count, an operation code and a core number. It turns that access into a sequence of line-aligned sub-requests, one for each cache line the byte range covers.

An access that fits inside one line produces a single sub-request. An access that runs past a line boundary produces one sub-request for every line it touches. For example, with 4-byte lines, 4 bytes starting at 0x2 produce two sub-requests: line 0x0 and line 0x4.

Both sides use a valid/ready handshake. The downstream side can stall the sequence at any cycle. A new access is taken only after the final sub-request of the current one has been accepted. The operation code and core number are copied unchanged onto every sub-request.

Top module: `line_span_splitter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sub_valid` is 0 and `req_ready` is 1.
- R2: The first sub-request of an access carries the request address with its low log2(LINE_BYTES) bits forced to zero. Every sub-request address has those bits at zero.
- R3: Each further sub-request of the same access has an address exactly LINE_BYTES above the one before it, so lines are issued in ascending order.
- R4: An access produces ((addr mod LINE_BYTES) + size − 1) / LINE_BYTES + 1 sub-requests. A `req_size` of 0 is handled as a size of 1.
- R5: `sub_last` is 1 on the final sub-request of an access and 0 on all earlier ones. The cycle after the final sub-request is accepted, `sub_valid` is 0.
- R6: `req_ready` goes to 0 in the cycle after an access is accepted. It stays at 0 until the cycle after the final sub-request is accepted (`sub_valid` and `sub_ready` both 1 while `sub_last` is 1).
- R7: `sub_op` and `sub_core` equal the `req_op` and `req_core` values sampled when the access was accepted, on every one of its sub-requests.
- R8: While `sub_valid` is 1 and `sub_ready` is 0, every sub-request output holds its value into the next cycle.
- R9: Addresses are ADDR_W bits wide (64 by default). An access near the top of the address space splits the same way as one anywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Number of bytes (0 handled as 1) |
| req_op | input | OP_W | Operation code, passed through |
| req_core | input | CORE_W | Requesting core number, passed through |
| sub_valid | output | 1 | Sub-request present |
| sub_ready | input | 1 | Downstream accepts the sub-request |
| sub_addr | output | ADDR_W | Line-aligned address of the sub-request |
| sub_op | output | OP_W | Copied operation code |
| sub_core | output | CORE_W | Copied core number |
| sub_last | output | 1 | Final sub-request of the access |

## Verification
The assertions check several rules on every cycle:
- Line alignment of every sub-request.
- Address steps of exactly one line between consecutive sub-requests.
- Output stability under backpressure.
- The blocked request side while a sequence is running.
- The gap after the final sub-request.
- Unchanged operation and core fields through a sequence.

The number of sub-requests per access, and the correct first line, can only be shown by the bench's scenarios. Its reference model compares every cycle. The scenarios cover:
- Unaligned starts.
- A zero size.
- Ranges ending exactly on a boundary.
- A 65-line span.
- An access at the top of the address space.
- Both steady and stalling downstream patterns.

// File: rtl/lss_pkg.sv
package lss_pkg;
   typedef enum logic {
      WALK_IDLE  = 1'b0,
      WALK_ISSUE = 1'b1
   } walk_state_e;
endpackage

// File: rtl/lss_span_calc.sv
module lss_span_calc #(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 8,
   parameter int OFS_W  = 4,
   localparam int SUM_W = SIZE_W + OFS_W + 1,
   localparam int CNT_W = SIZE_W + 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [ADDR_W-1:0] line_base_o,
   output logic [CNT_W-1:0]  extra_lines_o
);
   logic [SIZE_W-1:0] eff_size;
   logic [SUM_W-1:0]  end_ofs;

   // zero-byte access is handled as one byte
   assign eff_size = (size_i == '0) ? SIZE_W'(1) : size_i;

   // offset of the final byte measured from the first line base
   assign end_ofs = SUM_W'(addr_i[OFS_W-1:0]) + SUM_W'(eff_size) - SUM_W'(1);

   assign extra_lines_o = end_ofs[SUM_W-1:OFS_W];
   assign line_base_o   = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/lss_line_walker.sv
module lss_line_walker
   import lss_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int OP_W       = 2,
   parameter int CORE_W     = 2,
   parameter int CNT_W      = 9,
   parameter int LINE_BYTES = 16,
   localparam int OFS_W     = $clog2(LINE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  extra_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [CORE_W-1:0] core_i,
   output logic              busy_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [ADDR_W-1:0] out_addr_o,
   output logic [OP_W-1:0]   out_op_o,
   output logic [CORE_W-1:0] out_core_o,
   output logic              out_last_o
);
   walk_state_e       state_q;
   logic [ADDR_W-1:0] line_q;
   logic [CNT_W-1:0]  left_q;
   logic [OP_W-1:0]   op_q;
   logic [CORE_W-1:0] core_q;
   logic              take;

   assign take        = (state_q == WALK_ISSUE) && out_ready_i;
   assign busy_o      = (state_q == WALK_ISSUE);
   assign out_valid_o = (state_q == WALK_ISSUE);
   assign out_addr_o  = line_q;
   assign out_op_o    = op_q;
   assign out_core_o  = core_q;
   assign out_last_o  = (state_q == WALK_ISSUE) && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WALK_IDLE;
         line_q  <= '0;
         left_q  <= '0;
         op_q    <= '0;
         core_q  <= '0;
      end else begin
         case (state_q)
            WALK_IDLE: begin
               if (load_i) begin
                  state_q <= WALK_ISSUE;
                  line_q  <= base_i;
                  left_q  <= extra_i;
                  op_q    <= op_i;
                  core_q  <= core_i;
               end
            end
            default: begin
               if (take) begin
                  if (left_q == '0) begin
                     state_q <= WALK_IDLE;
                  end else begin
                     line_q <= line_q + ADDR_W'(LINE_BYTES);
                     left_q <= left_q - CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_addr_o[OFS_W-1:0] == '0)); // R2

   AST_ASCENDING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && !out_last_o) |=>
         (out_valid_o && (out_addr_o == $past(out_addr_o) + ADDR_W'(LINE_BYTES)))); // R3

   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o); // R5

   AST_FIELDS_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && !out_last_o) |=>
         ($stable(out_op_o) && $stable(out_core_o))); // R7

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=>
         (out_valid_o && $stable(out_addr_o) && $stable(out_last_o)
          && $stable(out_op_o) && $stable(out_core_o))); // R8
endmodule

// File: rtl/line_span_splitter.sv
module line_span_splitter #(
   parameter int ADDR_W     = 64,
   parameter int SIZE_W     = 8,
   parameter int OP_W       = 2,
   parameter int CORE_W     = 2,
   parameter int LINE_BYTES = 16,
   localparam int OFS_W     = $clog2(LINE_BYTES),
   localparam int CNT_W     = SIZE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [OP_W-1:0]   req_op,
   input  logic [CORE_W-1:0] req_core,
   output logic              sub_valid,
   input  logic              sub_ready,
   output logic [ADDR_W-1:0] sub_addr,
   output logic [OP_W-1:0]   sub_op,
   output logic [CORE_W-1:0] sub_core,
   output logic              sub_last
);
   generate
      if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
         $error("line_span_splitter: LINE_BYTES must be a power of two of at least 2");
      end
      if (OFS_W >= ADDR_W) begin : g_bad_addr
         $error("line_span_splitter: ADDR_W must exceed the line offset width");
      end
      if (SIZE_W < 1) begin : g_bad_size
         $error("line_span_splitter: SIZE_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] base_w;
   logic [CNT_W-1:0]  extra_w;
   logic              busy_w;
   logic              load_w;

   assign req_ready = !busy_w;
   assign load_w    = req_valid && !busy_w;

   lss_span_calc #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .OFS_W  (OFS_W)
   ) span_i (
      .addr_i        (req_addr),
      .size_i        (req_size),
      .line_base_o   (base_w),
      .extra_lines_o (extra_w)
   );

   lss_line_walker #(
      .ADDR_W     (ADDR_W),
      .OP_W       (OP_W),
      .CORE_W     (CORE_W),
      .CNT_W      (CNT_W),
      .LINE_BYTES (LINE_BYTES)
   ) walk_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_w),
      .base_i      (base_w),
      .extra_i     (extra_w),
      .op_i        (req_op),
      .core_i      (req_core),
      .busy_o      (busy_w),
      .out_valid_o (sub_valid),
      .out_ready_i (sub_ready),
      .out_addr_o  (sub_addr),
      .out_op_o    (sub_op),
      .out_core_o  (sub_core),
      .out_last_o  (sub_last)
   );

   AST_NO_ACCEPT_WHILE_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> !req_ready); // R6

   AST_ACCEPT_STARTS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (sub_valid && !req_ready)); // R6
endmodule

// File: tb/line_span_splitter_tb_top.sv
module line_span_splitter_tb_top;
   localparam int AW = 64;
   localparam int SW = 8;
   localparam int LB = 4;

   typedef struct {
      logic [AW-1:0] addr;
      logic [1:0]    op;
      logic [1:0]    core;
      logic          last;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = '0;
   logic [1:0]    req_op = '0;
   logic [1:0]    req_core = '0;
   logic          sub_valid;
   logic          sub_ready = 1'b1;
   logic [AW-1:0] sub_addr;
   logic [1:0]    sub_op;
   logic [1:0]    sub_core;
   logic          sub_last;

   int   n_chk = 0;
   int   n_fail = 0;
   int   stall_mode = 0;
   int   cyc = 0;
   exp_t q[$];

   always #5 clk = ~clk;

   line_span_splitter #(
      .ADDR_W (AW), .SIZE_W (SW), .OP_W (2), .CORE_W (2), .LINE_BYTES (LB)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_size (req_size), .req_op (req_op), .req_core (req_core),
      .sub_valid (sub_valid), .sub_ready (sub_ready), .sub_addr (sub_addr),
      .sub_op (sub_op), .sub_core (sub_core), .sub_last (sub_last)
   );

   // reference model: line list built from the requirement formula
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         q.delete();
      end else if (q.size() != 0) begin
         if (sub_ready) void'(q.pop_front());
      end else if (req_valid) begin
         longint unsigned base;
         int eff;
         int n;
         base = req_addr & ~(64'(LB) - 64'd1);
         eff  = (req_size == 0) ? 1 : int'(req_size);
         n    = (int'(req_addr % LB) + eff - 1) / LB + 1; // R4 count formula
         for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr = base + 64'(i * LB);
            e.op   = req_op;
            e.core = req_core;
            e.last = (i == n - 1);
            q.push_back(e);
         end
      end
   end

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      check("R1 R5 sub_valid", AW'(sub_valid), AW'(q.size() != 0));
      check("R1 R6 req_ready", AW'(req_ready), AW'(q.size() == 0));
      if (q.size() != 0 && sub_valid === 1'b1) begin
         check("R2 R3 R8 R9 sub_addr", sub_addr, q[0].addr);
         check("R7 sub_op", AW'(sub_op), AW'(q[0].op));
         check("R7 sub_core", AW'(sub_core), AW'(q[0].core));
         check("R4 R5 sub_last", AW'(sub_last), AW'(q[0].last));
      end
   end

   // downstream ready pattern
   always @(posedge clk) begin
      #1;
      case (stall_mode)
         0:       sub_ready = 1'b1;
         1:       sub_ready = (cyc % 3) != 0;
         default: sub_ready = (cyc % 5) == 2;
      endcase
   end

   task automatic send(input logic [AW-1:0] a, input int sz, input logic [1:0] op,
                       input logic [1:0] core);
      logic rdy;
      req_valid = 1'b1;
      req_addr  = a;
      req_size  = SW'(sz);
      req_op    = op;
      req_core  = core;
      do begin
         @(negedge clk);
         rdy = req_ready;
         @(posedge clk);
      end while (!rdy);
      #1 req_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      for (int m = 0; m < 3; m++) begin
         stall_mode = m;
         send(64'h2, 4, 2'd1, 2'd0);                   // R4 crossing example: two lines
         send(64'h10, 4, 2'd2, 2'd1);                  // R4 aligned, one line
         send(64'h7, 0, 2'd3, 2'd2);                   // R4 zero size as one byte
         send(64'h3, 1, 2'd0, 2'd3);                   // R4 last byte of a line
         send(64'h3, 2, 2'd1, 2'd1);                   // R3 just crosses
         send(64'h1, 16, 2'd2, 2'd3);                  // R3 five lines
         send(64'h20, 8, 2'd3, 2'd0);                  // R4 ends exactly on boundary
         send(64'hFFFF_FFFF_FFFF_FFF6, 8, 2'd1, 2'd2); // R9 top of address space
         drain();
      end
      stall_mode = 1;
      send(64'h1003, 255, 2'd2, 2'd1);                 // R4 65-line span under stalls
      drain();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
   end
endmodule